// File: doc/BRIEF.md
# Ethernet Port Mode Resolver

This block keeps one port's operation-mode control word and turns it into the link, speed, duplex and flow-control state that the MAC works with. A CPU reads and writes the control word through a small register bus. The same bus reads a saturating count of received flow-control frames, and each such read clears the count. A separate PHY-polling engine supplies the link status and the negotiated speed and duplex. This block tells that engine when it should poll.

The two upper bits of the control word pick one of four link policies: full auto-negotiation, limited (fixed speed and duplex with a live link status), forced down and forced up. The three lower bits give the manual speed, duplex and flow-control settings. Every resolved output is taken from a register. So a change to the control word or to the PHY status shows up at the outputs one clock later. Flow control drives one of two mutually exclusive transmitter enables: back-pressure in half duplex, or pause-frame sending in full duplex. It also gates the frame counter.

Top module: `eth_port_mode_resolver`

## Requirements
- R1: After reset, the control word and the frame count both read 0. One cycle after the synchronised reset release, the block runs auto-negotiation: `poll_en`=1 and `fc_enable`=1.
- R2: On the CPU bus, address 0 holds the control word in bits [4:0], and its upper bits read as 0. Address 1 holds the frame count. Read data appears on `cpu_rdata` in the cycle after the read strobe and holds until the next read. Writes to address 1 are ignored.
- R3: A write to the control word, or a change on the PHY status inputs, reaches the resolved outputs one clock after the register or input has taken the new value, and not earlier.
- R4: Link policy 2'b00 in bits [4:3] (auto): `poll_en`=1, and link, speed and duplex follow the PHY inputs. The PHY speed codes are 00=100M, 01=10M and 10=1000M, and 11 is taken as 100M. On `speed`, the output codes are 00=100M, 01=10M and 10=1000M.
- R5: Link policy 2'b01 (limited): `poll_en`=1, and the link follows the PHY. Speed and duplex come from bits [2:1], and the PHY speed and duplex inputs are ignored.
- R6: Link policy 2'b10 (forced down): `poll_en`=0, `link_up`=0, and both transmitter flow-control enables are 0.
- R7: Link policy 2'b11 (forced up): `poll_en`=0 and `link_up`=1 whatever the PHY link input is. Speed and duplex come from bits [2:1].
- R8: Bit 0 set to 1 turns flow control off (`fc_enable`=0). Bit 1 set to 1 selects half duplex. Bit 2 set to 1 selects 10M, and bit 2 set to 0 selects 100M.
- R9: A negotiated 1000M result always resolves to full duplex, even when the PHY reports half duplex.
- R10: With flow control on and the link up, `backpressure_en`=1 in half duplex and `pause_tx_en`=1 in full duplex. The two enables are never both 1.
- R11: Each cycle with `fc_frame_rx`=1 adds one to the count when flow control is on and the duplex is full. In every other case the strobe is ignored and the count holds.
- R12: The count saturates at 16'hFFFF.
- R13: A read of address 1 returns the count and clears it. If a counted strobe falls in the same cycle as that read, the count afterwards is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Bus select |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_addr | input | 1 | 0 = control word, 1 = frame count |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Registered read data |
| phy_link_up | input | 1 | Link status from the polling engine |
| phy_an_speed | input | 2 | Negotiated speed code |
| phy_an_half | input | 1 | Negotiated half duplex |
| poll_en | output | 1 | Enable to the polling engine |
| link_up | output | 1 | Resolved link |
| speed | output | 2 | Resolved speed code |
| half_duplex | output | 1 | Resolved half duplex |
| fc_enable | output | 1 | Flow control on |
| backpressure_en | output | 1 | Half-duplex back-pressure enable |
| pause_tx_en | output | 1 | Full-duplex pause-frame enable |
| fc_frame_rx | input | 1 | Received flow-control frame strobe |

## Verification
A clear-on-read of the frame count and a counted flow-control frame strobe can land on the same clock edge. The bench drives the read strobe and the frame strobe together for one cycle while the count holds 3. It then expects the read data to show 3 and a second read to show 1, so the arriving frame is neither lost nor merged into the cleared value. Saturation is checked against the same read path: an uninterrupted run of strobes must read back 16'hFFFF and then 0.

// File: rtl/eth_pmr_pkg.sv
package eth_pmr_pkg;
  localparam int MODE_W = 5;

  typedef enum logic [1:0] {
    LP_AUTO    = 2'b00,
    LP_LIMITED = 2'b01,
    LP_DOWN    = 2'b10,
    LP_UP      = 2'b11
  } link_policy_e;

  typedef enum logic [1:0] {
    SPD_100  = 2'b00,
    SPD_10   = 2'b01,
    SPD_1000 = 2'b10
  } spd_e;

  typedef struct packed {
    logic link;
    spd_e speed;
    logic half;
    logic fc_on;
    logic poll;
    logic bp;
    logic pause;
  } port_state_t;
endpackage

// File: rtl/pmr_rst_sync.sv
module pmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pmr_csr.sv
module pmr_csr
  import eth_pmr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic              cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [MODE_W-1:0] mode_q,
  output logic              cnt_clr
);
  logic [MODE_W-1:0] mode_d;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_mode;
  logic              rd_en;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^cpu_wdata[DATA_W-1:MODE_W];
  assign wr_mode = cpu_sel & cpu_wr & ~cpu_addr;
  assign rd_en   = cpu_sel & cpu_rd;
  assign cnt_clr = rd_en & cpu_addr;

  always_comb begin
    rd_mux = '0;
    if (cpu_addr) rd_mux[CNT_W-1:0]  = cnt_val;
    else          rd_mux[MODE_W-1:0] = mode_q;
  end

  always_comb begin
    mode_d  = mode_q;
    rdata_d = cpu_rdata;
    if (wr_mode) mode_d  = cpu_wdata[MODE_W-1:0];
    if (rd_en)   rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      cpu_rdata <= '0;
    end else begin
      mode_q    <= mode_d;
      cpu_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/pmr_resolve.sv
module pmr_resolve
  import eth_pmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_q,
  input  logic              phy_link_up,
  input  logic [1:0]        phy_an_speed,
  input  logic              phy_an_half,
  output port_state_t       state_q
);
  port_state_t  state_d;
  link_policy_e policy;
  spd_e         cfg_speed;
  spd_e         an_speed;

  assign policy    = link_policy_e'(mode_q[4:3]);
  assign cfg_speed = mode_q[2] ? SPD_10 : SPD_100;

  always_comb begin
    case (phy_an_speed)
      2'b01:   an_speed = SPD_10;
      2'b10:   an_speed = SPD_1000;
      default: an_speed = SPD_100;
    endcase
  end

  always_comb begin
    state_d       = '0;
    state_d.fc_on = ~mode_q[0];
    state_d.speed = cfg_speed;
    state_d.half  = mode_q[1];
    case (policy)
      LP_AUTO: begin
        state_d.link  = phy_link_up;
        state_d.poll  = 1'b1;
        state_d.speed = an_speed;
        state_d.half  = phy_an_half & (an_speed != SPD_1000);
      end
      LP_LIMITED: begin
        state_d.link = phy_link_up;
        state_d.poll = 1'b1;
      end
      LP_DOWN: begin
        state_d.link = 1'b0;
        state_d.poll = 1'b0;
      end
      default: begin
        state_d.link = 1'b1;
        state_d.poll = 1'b0;
      end
    endcase
    state_d.bp    = state_d.fc_on & state_d.link & state_d.half;
    state_d.pause = state_d.fc_on & state_d.link & ~state_d.half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pmr_fc_counter.sv
module pmr_fc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_ok,
  input  logic             strobe,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_d;
  logic             hit;

  assign hit = count_ok & strobe;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                        cnt_d = {{(CNT_W-1){1'b0}}, hit};
    else if (hit && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/eth_port_mode_resolver.sv
module eth_port_mode_resolver
  import eth_pmr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic              cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              phy_link_up,
  input  logic [1:0]        phy_an_speed,
  input  logic              phy_an_half,
  output logic              poll_en,
  output logic              link_up,
  output logic [1:0]        speed,
  output logic              half_duplex,
  output logic              fc_enable,
  output logic              backpressure_en,
  output logic              pause_tx_en,
  input  logic              fc_frame_rx
);
  logic              rst_sync_n;
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cnt_clr;
  port_state_t       state_q;

  pmr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pmr_csr #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_csr (
    .clk(clk), .rst_n(rst_sync_n),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cnt_val(cnt_q), .cpu_rdata(cpu_rdata),
    .mode_q(mode_q), .cnt_clr(cnt_clr)
  );

  pmr_resolve u_res (
    .clk(clk), .rst_n(rst_sync_n), .mode_q(mode_q),
    .phy_link_up(phy_link_up), .phy_an_speed(phy_an_speed),
    .phy_an_half(phy_an_half), .state_q(state_q)
  );

  pmr_fc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n),
    .count_ok(state_q.fc_on & ~state_q.half),
    .strobe(fc_frame_rx), .clr(cnt_clr), .cnt_q(cnt_q)
  );

  assign poll_en         = state_q.poll;
  assign link_up         = state_q.link;
  assign speed           = state_q.speed;
  assign half_duplex     = state_q.half;
  assign fc_enable       = state_q.fc_on;
  assign backpressure_en = state_q.bp;
  assign pause_tx_en     = state_q.pause;
endmodule

// File: rtl/pmr_checker.sv
module pmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [4:0]       mode_q,
  input logic             link_up,
  input logic             poll_en,
  input logic [1:0]       speed,
  input logic             half_duplex,
  input logic             fc_enable,
  input logic             bp,
  input logic             pause,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_clr
);
  p_force_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q[4:3]) == 2'b10) |-> (!link_up && !poll_en && !bp && !pause));

  p_force_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q[4:3]) == 2'b11) |-> (link_up && !poll_en));

  p_gig_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (speed == 2'b10) |-> !half_duplex);

  p_bp_pause_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bp && pause));

  p_fc_off_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fc_enable && !cnt_clr) |=> $stable(cnt));

  p_saturate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt) && !cnt_clr) |=> (&cnt));
endmodule

bind eth_port_mode_resolver pmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .mode_q(mode_q),
  .link_up(link_up), .poll_en(poll_en), .speed(speed),
  .half_duplex(half_duplex), .fc_enable(fc_enable),
  .bp(backpressure_en), .pause(pause_tx_en),
  .cnt(cnt_q), .cnt_clr(cnt_clr)
);

// File: tb/tb_eth_port_mode_resolver.sv
`timescale 1ns/1ps
module tb_eth_port_mode_resolver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_sel, cpu_wr, cpu_rd, cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic        phy_link_up, phy_an_half;
  logic [1:0]  phy_an_speed;
  logic        poll_en, link_up, half_duplex, fc_enable;
  logic        backpressure_en, pause_tx_en, fc_frame_rx;
  logic [1:0]  speed;
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  eth_port_mode_resolver dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .phy_link_up(phy_link_up),
    .phy_an_speed(phy_an_speed), .phy_an_half(phy_an_half),
    .poll_en(poll_en), .link_up(link_up), .speed(speed),
    .half_duplex(half_duplex), .fc_enable(fc_enable),
    .backpressure_en(backpressure_en), .pause_tx_en(pause_tx_en),
    .fc_frame_rx(fc_frame_rx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic cpu_write(input logic addr, input logic [15:0] data);
    @(negedge clk);
    cpu_sel = 1; cpu_wr = 1; cpu_addr = addr; cpu_wdata = data;
    @(negedge clk);
    cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic cpu_read(input logic addr, output logic [15:0] data);
    @(negedge clk);
    cpu_sel = 1; cpu_rd = 1; cpu_addr = addr;
    @(negedge clk);
    cpu_sel = 0; cpu_rd = 0;
    data = cpu_rdata;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fc_frame_rx = 1;
    end
    @(negedge clk);
    fc_frame_rx = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    cpu_read(1'b0, d); check("R1 mode reg", d, 16'h0);
    cpu_read(1'b1, d); check("R1 count", d, 16'h0);
    check("R1 poll_en", poll_en, 1); check("R1 fc_enable", fc_enable, 1);
  endtask

  task automatic t_auto();
    @(negedge clk); phy_link_up = 1; phy_an_speed = 2'b01; phy_an_half = 1;
    settle();
    check("R4 link", link_up, 1); check("R4 speed 10", speed, 2'b01);
    check("R4 half", half_duplex, 1); check("R10 bp", backpressure_en, 1);
    check("R10 pause", pause_tx_en, 0);
    phy_an_speed = 2'b10; settle();
    check("R9 gig speed", speed, 2'b10); check("R9 gig full", half_duplex, 0);
    check("R10 pause full", pause_tx_en, 1);
    phy_link_up = 0; settle();
    check("R4 link down", link_up, 0); check("R10 no pause", pause_tx_en, 0);
    phy_link_up = 1; settle();
  endtask

  task automatic t_limited();
    logic [15:0] d;
    cpu_write(1'b0, 16'h000E);
    check("R3 not yet", speed, 2'b10);
    settle();
    check("R5 speed", speed, 2'b01); check("R5 half", half_duplex, 1);
    check("R5 poll", poll_en, 1); check("R8 bp", backpressure_en, 1);
    phy_link_up = 0; settle(); settle();
    check("R5 link follows", link_up, 0);
    phy_link_up = 1;
    cpu_write(1'b0, 16'hFFEE);
    cpu_read(1'b0, d); check("R2 upper bits", d, 16'h000E);
    cpu_write(1'b1, 16'h1234);
    cpu_read(1'b1, d); check("R2 cnt write ignored", d, 16'h0);
  endtask

  task automatic t_force();
    cpu_write(1'b0, 16'h0010); settle();
    check("R6 link", link_up, 0); check("R6 poll", poll_en, 0);
    check("R6 pause", pause_tx_en, 0); check("R6 bp", backpressure_en, 0);
    phy_link_up = 0;
    cpu_write(1'b0, 16'h0019); settle();
    check("R7 link", link_up, 1); check("R7 poll", poll_en, 0);
    check("R8 fc off", fc_enable, 0); check("R8 speed 100", speed, 2'b00);
    check("R8 full", half_duplex, 0); check("R10 fc off pause", pause_tx_en, 0);
  endtask

  task automatic t_count();
    logic [15:0] d;
    strobes(3); cpu_read(1'b1, d); check("R11 fc off", d, 16'h0);
    cpu_write(1'b0, 16'h0018); settle();
    strobes(5); cpu_read(1'b1, d); check("R11 count", d, 16'd5);
    cpu_read(1'b1, d); check("R13 cleared", d, 16'h0);
    cpu_write(1'b0, 16'h001A); settle();
    strobes(2); cpu_read(1'b1, d); check("R11 half ignored", d, 16'h0);
    cpu_write(1'b0, 16'h0018); settle();
  endtask

  task automatic t_collide();
    logic [15:0] d;
    strobes(3);
    @(negedge clk);
    cpu_sel = 1; cpu_rd = 1; cpu_addr = 1; fc_frame_rx = 1;
    @(negedge clk);
    cpu_sel = 0; cpu_rd = 0; fc_frame_rx = 0;
    check("R13 read value", cpu_rdata, 16'd3);
    cpu_read(1'b1, d); check("R13 strobe kept", d, 16'd1);
  endtask

  task automatic t_sat();
    logic [15:0] d;
    strobes(65540);
    cpu_read(1'b1, d); check("R12 saturate", d, 16'hFFFF);
    cpu_read(1'b1, d); check("R12 clear", d, 16'h0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cpu_sel = 0; cpu_wr = 0; cpu_rd = 0; cpu_addr = 0;
    cpu_wdata = '0; phy_link_up = 0; phy_an_speed = 2'b00;
    phy_an_half = 0; fc_frame_rx = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_auto();
    t_limited();
    t_force();
    t_count();
    t_collide();
    t_sat();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule